// File: doc/BRIEF.md
# Link Training Stall Recovery Controller

This block supervises one downstream port of a serial point-to-point link. When software or a sequencer pulses `start_i`, it judges from the port's status flags whether speed negotiation is stuck, with the link retraining over and over and never reaching the data-link-up state. A link that looks healthy is left alone. A suspect link is watched for a timed window. If it does not settle, the controller lowers the target speed to the slowest code, asks for a retrain and watches a second, identical window.

A second window that passes leaves the low speed in place. A second window that fails writes the original target speed back. Each run ends with a one-cycle `done_o` pulse and a 2-bit result code. The window length is given in clock cycles by `WIN_CYC`. Its default is 200 ms at 100 MHz, and a bench can set it short.

Top module: `lnk_recover_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `done_o`, `spd_wr_o` and `retrain_o` are low. `result_o` and `spd_wdata_o` reset to 0.
- R2: A start with `dll_impl_i`=1 and `dll_act_i`=1 is a healthy link. On the next cycle `done_o` pulses with result 0 (healthy, no action), and there is no speed write and no retrain.
- R3: When `dll_impl_i`=0 the link is suspect only if `bw_mgmt_i`=1. With `bw_mgmt_i`=0 the outcome is the same as R2. With `dll_impl_i`=1 the link is suspect when `dll_act_i`=0.
- R4: An observation window lasts `WIN_CYC` cycles and begins on the cycle after the accepting start. If `dll_act_i` (counted only when `dll_impl_i`=1) is high on any window cycle, the window passes. A first window that passes gives `done_o` with result 0 on the cycle after the window.
- R5: A window also passes when `training_i` is low on every cycle of its second half. The second half is window cycles `WIN_CYC/2` to `WIN_CYC-1`, counting from 0.
- R6: `training_i` high during the first half has no bearing on the result. High on any second-half cycle, it defeats the quiet rule for that window without making the window longer.
- R7: When the first window fails, the current `cur_spd_i` is saved. On the next cycle `spd_wr_o` pulses with `spd_wdata_o`=1, the lowest speed. `retrain_o` pulses on the cycle after that, and the second window starts on the cycle after the retrain pulse.
- R8: When the second window passes, `done_o` pulses on the next cycle with result 1 (recovered at low speed), and no further speed write occurs.
- R9: When the second window fails, a single cycle carries `spd_wr_o` with the saved speed on `spd_wdata_o` together with `done_o` and result 2 (failed, restored).
- R10: `start_i` is ignored while a run is in progress. Each accepted start yields exactly one `done_o` pulse.
- R11: `done_o` lasts one cycle. `result_o` holds its value until the next completion and never shows the code 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a check (pulse) |
| dll_act_i | input | 1 | Data-link-layer active status |
| dll_impl_i | input | 1 | The active status flag is implemented |
| bw_mgmt_i | input | 1 | Bandwidth-management status (speed/width changed) |
| training_i | input | 1 | Link training in progress |
| cur_spd_i | input | SPD_W | Current target-speed setting |
| spd_wr_o | output | 1 | Target-speed write strobe |
| spd_wdata_o | output | SPD_W | Target-speed write value |
| retrain_o | output | 1 | Retrain request pulse |
| done_o | output | 1 | Run completed (pulse) |
| result_o | output | 2 | 0 healthy, 1 recovered low, 2 failed and restored |

## Verification
The bench targets the window edges. A training blip on the last first-half cycle must not count, and a blip on the first second-half cycle must fail the window. A design with the half boundary off by one would turn a recovered run into a failed one, or the reverse. The bench also checks the three-cycle hand-off of write, retrain and window start. A design that retrains before the write, or restores the speed on success, shows different strobes in those cycles. Start pulses given mid-run test that a busy controller does not restart its window or produce a second completion.

// File: rtl/lnk_recover_pkg.sv
package lnk_recover_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIN1,
        ST_LOWER,
        ST_RETRAIN,
        ST_WIN2
    } ctl_state_e;

    typedef enum logic [1:0] {
        RES_HEALTHY   = 2'd0,
        RES_RECOVERED = 2'd1,
        RES_FAILED    = 2'd2
    } run_result_e;

endpackage

// File: rtl/lnk_suspect_eval.sv
module lnk_suspect_eval (
    input  logic dll_act_i,
    input  logic dll_impl_i,
    input  logic bw_mgmt_i,
    output logic suspect_o,
    output logic link_up_o
);
    always_comb begin
        link_up_o = dll_impl_i & dll_act_i;
        if (dll_impl_i) begin
            suspect_o = ~dll_act_i;
        end else begin
            suspect_o = bw_mgmt_i;
        end
    end
endmodule

// File: rtl/lnk_win_judge.sv
module lnk_win_judge #(
    parameter int WIN_CYC = 20_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic begin_i,
    input  logic link_up_i,
    input  logic training_i,
    output logic end_o,
    output logic pass_o
);
    localparam int CW   = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam int HALF = WIN_CYC / 2;

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
        logic          seen;
        logic          quiet;
    } judge_t;

    judge_t s_q, s_d;
    logic   in_late;
    logic   last;

    always_comb begin
        s_d     = s_q;
        in_late = (s_q.cnt >= CW'(HALF));
        last    = s_q.act && (s_q.cnt == CW'(WIN_CYC - 1));
        end_o   = last;
        pass_o  = s_q.seen | link_up_i | (s_q.quiet & ~training_i);
        if (s_q.act) begin
            if (link_up_i) begin
                s_d.seen = 1'b1;
            end
            if (in_late && training_i) begin
                s_d.quiet = 1'b0;
            end
            if (last) begin
                s_d.act = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (begin_i) begin
            s_d.act   = 1'b1;
            s_d.cnt   = '0;
            s_d.seen  = 1'b0;
            s_d.quiet = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/lnk_recover_ctrl.sv
module lnk_recover_ctrl
    import lnk_recover_pkg::*;
#(
    parameter int WIN_CYC = 20_000_000,
    parameter int SPD_W   = 4,
    parameter int LOW_SPD = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             dll_act_i,
    input  logic             dll_impl_i,
    input  logic             bw_mgmt_i,
    input  logic             training_i,
    input  logic [SPD_W-1:0] cur_spd_i,
    output logic             spd_wr_o,
    output logic [SPD_W-1:0] spd_wdata_o,
    output logic             retrain_o,
    output logic             done_o,
    output logic [1:0]       result_o
);
    localparam logic [SPD_W-1:0] LOW_CODE = SPD_W'(LOW_SPD);

    typedef struct packed {
        ctl_state_e       st;
        logic             wr;
        logic [SPD_W-1:0] wdata;
        logic             retrain;
        logic             done;
        logic [1:0]       result;
        logic [SPD_W-1:0] saved;
    } ctl_t;

    ctl_t c_q, c_d;
    logic suspect;
    logic link_up;
    logic win_begin;
    logic win_end;
    logic win_pass;

    lnk_suspect_eval i_eval (
        .dll_act_i  (dll_act_i),
        .dll_impl_i (dll_impl_i),
        .bw_mgmt_i  (bw_mgmt_i),
        .suspect_o  (suspect),
        .link_up_o  (link_up)
    );

    lnk_win_judge #(.WIN_CYC(WIN_CYC)) i_judge (
        .clk        (clk),
        .rst        (rst),
        .begin_i    (win_begin),
        .link_up_i  (link_up),
        .training_i (training_i),
        .end_o      (win_end),
        .pass_o     (win_pass)
    );

    always_comb begin
        c_d         = c_q;
        c_d.wr      = 1'b0;
        c_d.retrain = 1'b0;
        c_d.done    = 1'b0;
        win_begin   = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (suspect) begin
                        win_begin = 1'b1;
                        c_d.st    = ST_WIN1;
                    end else begin
                        c_d.done   = 1'b1;
                        c_d.result = RES_HEALTHY;
                    end
                end
            end
            ST_WIN1: begin
                if (win_end) begin
                    if (win_pass) begin
                        c_d.done   = 1'b1;
                        c_d.result = RES_HEALTHY;
                        c_d.st     = ST_IDLE;
                    end else begin
                        c_d.saved = cur_spd_i;
                        c_d.wr    = 1'b1;
                        c_d.wdata = LOW_CODE;
                        c_d.st    = ST_LOWER;
                    end
                end
            end
            ST_LOWER: begin
                c_d.retrain = 1'b1;
                c_d.st      = ST_RETRAIN;
            end
            ST_RETRAIN: begin
                win_begin = 1'b1;
                c_d.st    = ST_WIN2;
            end
            ST_WIN2: begin
                if (win_end) begin
                    c_d.done = 1'b1;
                    c_d.st   = ST_IDLE;
                    if (win_pass) begin
                        c_d.result = RES_RECOVERED;
                    end else begin
                        c_d.wr     = 1'b1;
                        c_d.wdata  = c_q.saved;
                        c_d.result = RES_FAILED;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign spd_wr_o    = c_q.wr;
    assign spd_wdata_o = c_q.wdata;
    assign retrain_o   = c_q.retrain;
    assign done_o      = c_q.done;
    assign result_o    = c_q.result;
endmodule

// File: rtl/lnk_recover_chk.sv
module lnk_recover_chk #(
    parameter int SPD_W   = 4,
    parameter int LOW_SPD = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             spd_wr_o,
    input logic [SPD_W-1:0] spd_wdata_o,
    input logic             retrain_o,
    input logic             done_o,
    input logic [1:0]       result_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!done_o && !spd_wr_o && !retrain_o));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_result_code_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_o != 2'd3));

    assert_retrain_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        retrain_o |=> !retrain_o);

    assert_retrain_after_low_R7: assert property (@(posedge clk) disable iff (rst)
        retrain_o |-> ($past(spd_wr_o) && $past(spd_wdata_o) == SPD_W'(LOW_SPD)));

    assert_lower_write_R7: assert property (@(posedge clk) disable iff (rst)
        (spd_wr_o && !done_o) |=> retrain_o);

    assert_restore_with_fail_R9: assert property (@(posedge clk) disable iff (rst)
        (spd_wr_o && done_o) |-> (result_o == 2'd2));

    assert_no_retrain_done_R8: assert property (@(posedge clk) disable iff (rst)
        !(retrain_o && done_o));
endmodule

bind lnk_recover_ctrl lnk_recover_chk #(.SPD_W(SPD_W), .LOW_SPD(LOW_SPD)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .spd_wr_o    (spd_wr_o),
    .spd_wdata_o (spd_wdata_o),
    .retrain_o   (retrain_o),
    .done_o      (done_o),
    .result_o    (result_o)
);

// File: tb/test_lnk_recover_ctrl.sv
module test_lnk_recover_ctrl;
    localparam int WIN   = 8;
    localparam int HALF  = WIN / 2;
    localparam int SPD_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic             dll_act_i = 1'b0;
    logic             dll_impl_i = 1'b0;
    logic             bw_mgmt_i = 1'b0;
    logic             training_i = 1'b0;
    logic [SPD_W-1:0] cur_spd_i = 4'd3;
    logic             spd_wr_o;
    logic [SPD_W-1:0] spd_wdata_o;
    logic             retrain_o;
    logic             done_o;
    logic [1:0]       result_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    lnk_recover_ctrl #(.WIN_CYC(WIN), .SPD_W(SPD_W), .LOW_SPD(1)) i_lnk_recover_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .dll_act_i(dll_act_i),
        .dll_impl_i(dll_impl_i), .bw_mgmt_i(bw_mgmt_i), .training_i(training_i),
        .cur_spd_i(cur_spd_i), .spd_wr_o(spd_wr_o), .spd_wdata_o(spd_wdata_o),
        .retrain_o(retrain_o), .done_o(done_o), .result_o(result_o)
    );

    // behavioural reference: phase 0 idle, 1 first watch, 2 lowering, 3 retrain, 4 second watch
    int m_phase = 0, m_cnt = 0, m_saved = 0;
    bit m_seen = 0, m_quiet = 1;
    int e_wr = 0, e_wd = 0, e_rt = 0, e_done = 0, e_res = 0;

    always @(posedge clk) begin
        bit ok, pass;
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_saved = 0; m_seen = 0; m_quiet = 1;
            e_wr = 0; e_wd = 0; e_rt = 0; e_done = 0; e_res = 0;
        end else begin
            e_wr = 0; e_rt = 0; e_done = 0;
            ok = dll_impl_i && dll_act_i;
            if (m_phase == 0) begin
                if (start_i) begin
                    if ((dll_impl_i && !dll_act_i) || (!dll_impl_i && bw_mgmt_i)) begin
                        m_phase = 1; m_cnt = 0; m_seen = 0; m_quiet = 1;
                    end else begin
                        e_done = 1; e_res = 0;
                    end
                end
            end else if (m_phase == 1 || m_phase == 4) begin
                if (ok) m_seen = 1;
                if (m_cnt >= HALF && training_i) m_quiet = 0;
                if (m_cnt == WIN - 1) begin
                    pass = m_seen || m_quiet;
                    if (m_phase == 1) begin
                        if (pass) begin
                            e_done = 1; e_res = 0; m_phase = 0;
                        end else begin
                            m_saved = int'(cur_spd_i); e_wr = 1; e_wd = 1; m_phase = 2;
                        end
                    end else begin
                        e_done = 1; m_phase = 0;
                        if (pass) e_res = 1;
                        else begin
                            e_res = 2; e_wr = 1; e_wd = m_saved;
                        end
                    end
                end else begin
                    m_cnt++;
                end
            end else if (m_phase == 2) begin
                e_rt = 1; m_phase = 3;
            end else begin
                m_phase = 4; m_cnt = 0; m_seen = 0; m_quiet = 1;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    int done_cnt = 0;
    int last_res = -1;
    int wr_cnt = 0;
    int last_wd = -1;

    always @(negedge clk) begin
        cycles++;
        chk(cur_req, "spd_wr_o", int'(spd_wr_o), e_wr);
        chk(cur_req, "spd_wdata_o", int'(spd_wdata_o), e_wd);
        chk(cur_req, "retrain_o", int'(retrain_o), e_rt);
        chk(cur_req, "done_o", int'(done_o), e_done);
        chk(cur_req, "result_o", int'(result_o), e_res);
        if (done_o) begin done_cnt++; last_res = int'(result_o); end
        if (spd_wr_o) begin wr_cnt++; last_wd = int'(spd_wdata_o); end
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        tick(1);
        start_i = 1'b0;
    endtask

    task automatic scen_begin(string req);
        cur_req = req; done_cnt = 0; last_res = -1; wr_cnt = 0; last_wd = -1;
    endtask

    task automatic scen_end(string req, int exp_res, int exp_wr, int exp_wd);
        chk(req, "done pulse count", done_cnt, 1);
        chk(req, "final result", last_res, exp_res);
        chk(req, "speed write count", wr_cnt, exp_wr);
        if (exp_wr > 0) chk(req, "last written speed", last_wd, exp_wd);
    endtask

    initial begin
        tick(3);
        chk("R1", "done in reset", int'(done_o), 0);
        chk("R1", "result in reset", int'(result_o), 0);
        rst = 1'b0;
        tick(1);
        chk("R1", "write after reset", int'(spd_wr_o), 0);

        // R2: active link flag up at start
        scen_begin("R2");
        dll_impl_i = 1; dll_act_i = 1;
        pulse_start();
        tick(3);
        scen_end("R2", 0, 0, 0);

        // R3: flag not implemented, no bandwidth event
        scen_begin("R3");
        dll_impl_i = 0; dll_act_i = 1; bw_mgmt_i = 0; training_i = 1;
        pulse_start();
        tick(3);
        scen_end("R3", 0, 0, 0);

        // R5: bandwidth event, training quiet throughout
        scen_begin("R5");
        bw_mgmt_i = 1; training_i = 0;
        pulse_start();
        tick(WIN + 3);
        scen_end("R5", 0, 0, 0);

        // R4: training stays on, link comes up mid window
        scen_begin("R4");
        dll_impl_i = 1; dll_act_i = 0; training_i = 1;
        pulse_start();
        tick(2);
        dll_act_i = 1; tick(1); dll_act_i = 0;
        tick(WIN + 2);
        scen_end("R4", 0, 0, 0);

        // R6: training on through last first-half cycle only
        scen_begin("R6");
        dll_impl_i = 0; bw_mgmt_i = 1; training_i = 1;
        pulse_start();
        tick(HALF);
        training_i = 0;
        tick(WIN + 2);
        scen_end("R6", 0, 0, 0);

        // R6/R7/R8: one blip on first second-half cycle, then recovery by quiet
        scen_begin("R8");
        training_i = 0; cur_spd_i = 4'd3;
        pulse_start();
        tick(HALF); training_i = 1; tick(1); training_i = 0;
        tick(HALF + 2 + WIN + 3);
        scen_end("R8", 1, 1, 1);

        // R7/R9: link never settles, original speed restored
        scen_begin("R9");
        dll_impl_i = 1; dll_act_i = 0; training_i = 1; cur_spd_i = 4'd3;
        pulse_start();
        tick(WIN + 2 + WIN + 3);
        scen_end("R9", 2, 2, 3);

        // R7/R8: link up in second window at cycle after retrain
        scen_begin("R7");
        cur_spd_i = 4'd2;
        pulse_start();
        tick(WIN + 2);
        dll_act_i = 1; tick(1); dll_act_i = 0;
        tick(WIN + 2);
        scen_end("R7", 1, 1, 1);

        // R10: extra starts while busy are ignored
        scen_begin("R10");
        training_i = 1;
        pulse_start();
        tick(2); pulse_start();
        tick(WIN + 1); pulse_start();
        tick(WIN + 4);
        scen_end("R10", 2, 2, 2);

        // R11: result holds after done
        cur_req = "R11";
        tick(4);
        chk("R11", "result held", int'(result_o), 2);
        chk("R11", "done idle", int'(done_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule